// File: doc/BRIEF.md
# PRBS Error Checker with Self-Seeding Reference

This block sits behind a clock and data recovery stage and takes one recovered bit per clock. It rebuilds the expected test pattern locally and compares each incoming bit against it. A mismatch raises a one-cycle error strobe and is added to a running error total. A second total counts every bit compared. Together the two totals give the bit error ratio over any interval that software chooses.

The expected pattern is one of two kinds. The first is a maximal-length pseudo-random sequence of order 7, 15, 23 or 31. The second is a repeating 32-bit user word.

The block needs no start-up alignment from outside. It loads its reference from the received stream and then checks that the loaded reference predicts the following bits. It declares lock only after that check succeeds. Errors and bits are counted only while the block is locked. If the error density gets too high, the block drops lock and starts seeding again.

Top module: `prbs_err_chk`

## Requirements
- R1: While `rst_n` is low and on the first clock after it rises, `locked`, `err_strobe`, `err_count` and `bit_count` are all zero.
- R2: With `pat_sel`=0, `order_sel` picks the sequence rule next = b[k-n] XOR b[k-m]. The encodings are 0 → (n=7,m=6), 1 → (15,14), 2 → (23,18) and 3 → (31,28). A clean sequence of any order is followed with no errors.
- R3: In sequence mode the reference is loaded from the last n received bits. A window of n zeros is never accepted as a seed, so an all-zero stream never produces lock.
- R4: With `pat_sel`=1 the pattern is `user_word` sent MSB first and repeated. A 32-bit received window that equals any of the 32 rotations of the word is accepted as a seed. A window that matches no rotation, such as all zeros with a non-zero word, keeps the block seeding.
- R5: After the seed is accepted, 64 consecutive correct predictions set `locked`. On a clean stream, `locked` reads 1 after bit L+64 and 0 after bit L+63, where L is n in sequence mode and 32 in user mode. A mismatch during this verification phase restarts seeding from the next bit.
- R6: While locked, a mismatched bit sets `err_strobe` for the cycle after that bit. The reference keeps running on its own prediction, so an errored bit does not disturb later comparisons.
- R7: `bit_count` adds one for each bit received while `locked` is already 1. `err_count` adds one for each such bit that mismatches. Neither counter changes while unlocked.
- R8: While locked, the 16th error within any span of 64 consecutive bits clears `locked` after that bit. That error is still counted, and seeding then restarts.
- R9: Both counters are CNT_W bits wide (48 by default) and hold at all ones instead of wrapping.
- R10: `clr` zeroes both counters on the next clock and takes priority over an increment in the same cycle. It has no effect on `locked` or `err_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of both counters |
| pat_sel | input | 1 | 0 = pseudo-random sequence, 1 = repeating user word |
| order_sel | input | 2 | Sequence order select (0:7, 1:15, 2:23, 3:31) |
| user_word | input | PAT_W | Repeating pattern word, MSB sent first |
| rx_bit | input | 1 | Received data bit |
| err_strobe | output | 1 | High for one cycle after a mismatched bit while locked |
| err_count | output | CNT_W | Saturating count of errored bits |
| bit_count | output | CNT_W | Saturating count of compared bits |
| locked | output | 1 | Reference synchronised to the stream |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a counter clear and an error increment. The bench raises `clr` on the very bit it corrupts. It then expects both counters at zero while `err_strobe` still reads 1, and it expects counting to resume normally on the bits that follow. The second pair is an error being counted and lock being lost. Sixteen corrupted bits are sent back to back: after the 15th, lock must still hold, and after the 16th, `locked` must fall with the 16th error already included in the total.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

   typedef enum logic [1:0] {
      ST_SEED   = 2'd0,
      ST_VERIFY = 2'd1,
      ST_LOCK   = 2'd2
   } chk_state_e;

   // register length of the selected sequence order
   function automatic logic [5:0] prbs_order_len(input logic [1:0] sel);
      logic [5:0] len;
      unique case (sel)
         2'd0:    len = 6'd7;
         2'd1:    len = 6'd15;
         2'd2:    len = 6'd23;
         default: len = 6'd31;
      endcase
      return len;
   endfunction

endpackage

// File: rtl/prbs_sat_cnt.sv
module prbs_sat_cnt #(
   parameter int W = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);

   generate
      if (W < 2) begin : g_bad_w
         $error("prbs_sat_cnt: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                     count <= '0;
      else if (clr)                   count <= '0;
      else if (inc && (count != '1))  count <= count + 1'b1;
   end

   AST_CNT_HOLD_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '1 && !clr) |=> (count == '1)); // R9

   AST_CNT_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0)); // R10

endmodule

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen
   import prbs_chk_pkg::*;
#(
   parameter int PAT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             user_mode,
   input  logic [1:0]       order_sel,
   input  logic [PAT_W-1:0] user_word,
   input  logic             load_rx,
   input  logic             rx_bit,
   output logic             pred_bit,
   output logic             seed_ok
);

   generate
      if (PAT_W < 31) begin : g_bad_pat
         $error("prbs_ref_gen: PAT_W must hold the longest sequence register");
      end
   endgenerate

   logic [PAT_W-1:0]   ref_q;
   logic [PAT_W-1:0]   cand;
   logic [PAT_W-1:0]   rot_hit;
   logic [2*PAT_W-1:0] word_dbl;
   logic               prbs_pred;
   logic               prbs_nz;
   logic               ref_nz;

   // candidate seed: history with the newest received bit in bit 0
   assign cand     = {ref_q[PAT_W-2:0], rx_bit};
   assign word_dbl = {user_word, user_word};

   // parallel compare against every rotation of the user word
   generate
      for (genvar r = 0; r < PAT_W; r++) begin : g_rot
         assign rot_hit[r] = (cand == word_dbl[2*PAT_W-1-r -: PAT_W]);
      end
   endgenerate

   always_comb begin
      unique case (order_sel)
         2'd0: begin
            prbs_pred = ref_q[6]  ^ ref_q[5];
            prbs_nz   = |cand[6:0];
            ref_nz    = |ref_q[6:0];
         end
         2'd1: begin
            prbs_pred = ref_q[14] ^ ref_q[13];
            prbs_nz   = |cand[14:0];
            ref_nz    = |ref_q[14:0];
         end
         2'd2: begin
            prbs_pred = ref_q[22] ^ ref_q[17];
            prbs_nz   = |cand[22:0];
            ref_nz    = |ref_q[22:0];
         end
         default: begin
            prbs_pred = ref_q[30] ^ ref_q[27];
            prbs_nz   = |cand[30:0];
            ref_nz    = |ref_q[30:0];
         end
      endcase
   end

   assign pred_bit = user_mode ? ref_q[PAT_W-1] : prbs_pred;
   assign seed_ok  = user_mode ? (|rot_hit)     : prbs_nz;

   always_ff @(posedge clk) begin
      if (!rst_n)       ref_q <= '0;
      else if (load_rx) ref_q <= cand;
      else              ref_q <= {ref_q[PAT_W-2:0], pred_bit};
   end

   // a free-running sequence register started from a non-zero seed stays non-zero
   AST_PRBS_REF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!user_mode && !load_rx) |-> ref_nz); // R3

endmodule

// File: rtl/prbs_lock_fsm.sv
module prbs_lock_fsm
   import prbs_chk_pkg::*;
#(
   parameter int PAT_W    = 32,
   parameter int LOCK_RUN = 64,
   parameter int WIN_LEN  = 64,
   parameter int LOSS_THR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       user_mode,
   input  logic [1:0] order_sel,
   input  logic       rx_bit,
   input  logic       pred_bit,
   input  logic       seed_ok,
   output logic       load_rx,
   output logic       locked,
   output logic       err_hit
);

   localparam int FILL_W = $clog2(PAT_W + 2);
   localparam int RUN_W  = $clog2(LOCK_RUN + 1);
   localparam int WCNT_W = $clog2(WIN_LEN + 1);

   generate
      if (LOSS_THR < 1 || LOSS_THR > WIN_LEN) begin : g_bad_thr
         $error("prbs_lock_fsm: LOSS_THR must lie in 1..WIN_LEN");
      end
      if (WIN_LEN < 2 || LOCK_RUN < 1) begin : g_bad_len
         $error("prbs_lock_fsm: WIN_LEN >= 2 and LOCK_RUN >= 1 required");
      end
   endgenerate

   chk_state_e          state_q, state_d;
   logic [FILL_W-1:0]   fill_q, fill_d, seed_len, fill_inc;
   logic [RUN_W-1:0]    run_q, run_d;
   logic [WCNT_W-1:0]   win_q, win_d, win_nx;
   logic [WIN_LEN-1:0]  hist_q, hist_d;
   logic                mismatch;

   assign mismatch = rx_bit ^ pred_bit;
   assign seed_len = user_mode ? FILL_W'(PAT_W) : FILL_W'(prbs_order_len(order_sel));
   assign fill_inc = fill_q + 1'b1;
   assign win_nx   = win_q + WCNT_W'(mismatch) - WCNT_W'(hist_q[WIN_LEN-1]);

   always_comb begin
      state_d = state_q;
      fill_d  = fill_q;
      run_d   = run_q;
      win_d   = win_q;
      hist_d  = hist_q;
      unique case (state_q)
         ST_SEED: begin
            if (fill_q < seed_len) fill_d = fill_inc;
            if ((fill_inc >= seed_len) && seed_ok) begin
               state_d = ST_VERIFY;
               run_d   = '0;
            end
         end
         ST_VERIFY: begin
            if (mismatch) begin
               state_d = ST_SEED;
               fill_d  = '0;
            end else if (run_q == RUN_W'(LOCK_RUN - 1)) begin
               state_d = ST_LOCK;
               win_d   = '0;
               hist_d  = '0;
            end else begin
               run_d = run_q + 1'b1;
            end
         end
         default: begin
            hist_d = {hist_q[WIN_LEN-2:0], mismatch};
            win_d  = win_nx;
            if (win_nx >= WCNT_W'(LOSS_THR)) begin
               state_d = ST_SEED;
               fill_d  = '0;
               win_d   = '0;
               hist_d  = '0;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_SEED;
         fill_q  <= '0;
         run_q   <= '0;
         win_q   <= '0;
         hist_q  <= '0;
      end else begin
         state_q <= state_d;
         fill_q  <= fill_d;
         run_q   <= run_d;
         win_q   <= win_d;
         hist_q  <= hist_d;
      end
   end

   assign load_rx = (state_q == ST_SEED);
   assign locked  = (state_q == ST_LOCK);
   assign err_hit = locked & mismatch;

   AST_WIN_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
      win_q < WCNT_W'(LOSS_THR)); // R8

   AST_VERIFY_MISS_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_VERIFY && mismatch) |=> (state_q == ST_SEED)); // R5

   AST_LOCK_ONLY_FROM_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEED) |=> (state_q != ST_LOCK)); // R5

endmodule

// File: rtl/prbs_err_chk.sv
module prbs_err_chk
   import prbs_chk_pkg::*;
#(
   parameter int PAT_W    = 32,
   parameter int CNT_W    = 48,
   parameter int LOCK_RUN = 64,
   parameter int WIN_LEN  = 64,
   parameter int LOSS_THR = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             pat_sel,
   input  logic [1:0]       order_sel,
   input  logic [PAT_W-1:0] user_word,
   input  logic             rx_bit,
   output logic             err_strobe,
   output logic [CNT_W-1:0] err_count,
   output logic [CNT_W-1:0] bit_count,
   output logic             locked
);

   logic pred_bit;
   logic seed_ok;
   logic load_rx;
   logic err_hit;

   prbs_ref_gen #(
      .PAT_W (PAT_W)
   ) u_ref (
      .clk       (clk),
      .rst_n     (rst_n),
      .user_mode (pat_sel),
      .order_sel (order_sel),
      .user_word (user_word),
      .load_rx   (load_rx),
      .rx_bit    (rx_bit),
      .pred_bit  (pred_bit),
      .seed_ok   (seed_ok)
   );

   prbs_lock_fsm #(
      .PAT_W    (PAT_W),
      .LOCK_RUN (LOCK_RUN),
      .WIN_LEN  (WIN_LEN),
      .LOSS_THR (LOSS_THR)
   ) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .user_mode (pat_sel),
      .order_sel (order_sel),
      .rx_bit    (rx_bit),
      .pred_bit  (pred_bit),
      .seed_ok   (seed_ok),
      .load_rx   (load_rx),
      .locked    (locked),
      .err_hit   (err_hit)
   );

   prbs_sat_cnt #(.W(CNT_W)) u_err_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (err_hit),
      .count (err_count)
   );

   prbs_sat_cnt #(.W(CNT_W)) u_bit_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (locked),
      .count (bit_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) err_strobe <= 1'b0;
      else        err_strobe <= err_hit;
   end

   AST_STROBE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      err_strobe |-> $past(locked)); // R6

   AST_ERR_COUNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (err_strobe && !$past(clr)) |->
         ((err_count == $past(err_count) + 1'b1) || (err_count == '1))); // R7

   AST_BIT_COUNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(locked) && !$past(clr)) |->
         ((bit_count == $past(bit_count) + 1'b1) || (bit_count == '1))); // R7

   AST_UNLOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && !clr) |=> $stable(bit_count)); // R7

endmodule

// File: tb/prbs_err_chk_tb.sv
`timescale 1ns/1ps
module prbs_err_chk_tb;

   localparam int CW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0;
   logic          pat_sel = 1'b0;
   logic [1:0]    order_sel = 2'd0;
   logic [31:0]   user_word = 32'h0;
   logic          rx_bit = 1'b0;
   logic          err_strobe;
   logic [CW-1:0] err_count;
   logic [CW-1:0] bit_count;
   logic          locked;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // bench pattern source
   logic [31:0] g_hist;
   int          g_n, g_m, g_idx;
   logic        g_user;
   logic [31:0] g_word;

   always #2 clk = ~clk;

   prbs_err_chk #(.CNT_W(CW)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .pat_sel    (pat_sel),
      .order_sel  (order_sel),
      .user_word  (user_word),
      .rx_bit     (rx_bit),
      .err_strobe (err_strobe),
      .err_count  (err_count),
      .bit_count  (bit_count),
      .locked     (locked)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic next_bit(output logic b);
      if (g_user) begin
         b = g_word[31 - (g_idx % 32)];
         g_idx++;
      end else begin
         b = g_hist[g_n-1] ^ g_hist[g_m-1];
         g_hist = {g_hist[30:0], b};
      end
   endtask

   task automatic send(input logic flip);
      logic b;
      next_bit(b);
      rx_bit = b ^ flip;
      @(negedge clk);
   endtask

   task automatic send_n(input int k);
      for (int i = 0; i < k; i++) send(1'b0);
   endtask

   task automatic send_raw(input logic b, input int k);
      for (int i = 0; i < k; i++) begin
         rx_bit = b;
         @(negedge clk);
      end
   endtask

   task automatic do_reset(input logic usr, input logic [1:0] sel,
                           input logic [31:0] word, input int phase);
      rst_n     = 1'b0;
      pat_sel   = usr;
      order_sel = sel;
      user_word = word;
      g_user    = usr;
      g_word    = word;
      g_idx     = phase;
      g_hist    = 32'h1;
      unique case (sel)
         2'd0:    begin g_n = 7;  g_m = 6;  end
         2'd1:    begin g_n = 15; g_m = 14; end
         2'd2:    begin g_n = 23; g_m = 18; end
         default: begin g_n = 31; g_m = 28; end
      endcase
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired before the run completed");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // ---------- sequence order 7: acquisition, errors, loss, clear
      do_reset(1'b0, 2'd0, 32'h0, 0);
      chk("R1", "locked", locked, 0);
      chk("R1", "err_count", err_count, 0);
      chk("R1", "bit_count", bit_count, 0);
      chk("R1", "err_strobe", err_strobe, 0);

      send_n(36);
      send(1'b1);                      // bit 37 errored during verification
      send_n(70);                      // bit 107
      chk("R5", "locked before reseed completes", locked, 0);
      send(1'b0);                      // bit 108 = 37 + 7 + 64
      chk("R5", "locked after reseed", locked, 1);
      chk("R7", "bit_count at lock", bit_count, 0);

      send_n(200);
      chk("R7", "bit_count after 200", bit_count, 200);
      chk("R7", "err_count clean", err_count, 0);

      send(1'b1);
      chk("R6", "strobe on error", err_strobe, 1);
      chk("R6", "err_count one", err_count, 1);
      chk("R6", "lock held", locked, 1);
      send(1'b0);
      chk("R6", "strobe clears", err_strobe, 0);
      send_n(100);
      chk("R6", "reference undisturbed", err_count, 1);

      for (int i = 0; i < 15; i++) send(1'b1);
      chk("R8", "lock at 15 errors", locked, 1);
      chk("R8", "err_count 16", err_count, 16);
      send(1'b1);
      chk("R8", "lock lost at 16th", locked, 0);
      chk("R8", "16th counted", err_count, 17);
      chk("R7", "bit_count at loss", bit_count, 318);

      send_n(70);
      chk("R7", "bit_count frozen unlocked", bit_count, 318);
      chk("R7", "err_count frozen unlocked", err_count, 17);
      chk("R5", "still seeding", locked, 0);
      send(1'b0);
      chk("R5", "relock", locked, 1);

      clr = 1'b1;
      send(1'b1);                      // clear and error in the same cycle
      clr = 1'b0;
      chk("R10", "err_count cleared", err_count, 0);
      chk("R10", "bit_count cleared", bit_count, 0);
      chk("R10", "strobe kept", err_strobe, 1);
      chk("R10", "lock kept", locked, 1);
      send_n(10);
      chk("R10", "bit_count resumes", bit_count, 10);
      chk("R10", "err_count resumes", err_count, 0);

      for (int j = 0; j < 5500; j++) send(j % 5 == 0);
      chk("R9", "err_count saturates", err_count, (1 << CW) - 1);
      chk("R9", "bit_count saturates", bit_count, (1 << CW) - 1);
      chk("R8", "13 per window keeps lock", locked, 1);

      // ---------- sweep every sequence order
      for (int s = 0; s < 4; s++) begin
         do_reset(1'b0, 2'(s), 32'h0, 0);
         send_n(g_n + 63);
         chk("R5", "unlocked at L+63", locked, 0);
         send(1'b0);
         chk("R5", "locked at L+64", locked, 1);
         send_n(300);
         chk("R2", "order bit_count", bit_count, 300);
         chk("R2", "order no errors", err_count, 0);
      end

      // ---------- all-zero stream in sequence mode
      do_reset(1'b0, 2'd1, 32'h0, 0);
      send_raw(1'b0, 200);
      chk("R3", "zero stream no lock", locked, 0);
      send_n(400);
      chk("R3", "locks once data present", locked, 1);

      // ---------- user word at several phases
      for (int p = 0; p < 3; p++) begin
         int ph;
         ph = (p == 0) ? 0 : ((p == 1) ? 9 : 31);
         do_reset(1'b1, 2'd0, 32'hC0FFEE15, ph);
         send_n(95);
         chk("R4", "user unlocked at 95", locked, 0);
         send(1'b0);
         chk("R4", "user locked at 96", locked, 1);
         send_n(64);
         chk("R4", "user bit_count", bit_count, 64);
         chk("R4", "user no errors", err_count, 0);
         send(1'b1);
         chk("R6", "user error strobe", err_strobe, 1);
      end

      do_reset(1'b1, 2'd0, 32'hC0FFEE15, 0);
      send_raw(1'b0, 200);
      chk("R4", "no rotation match no lock", locked, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule